// File: doc/BRIEF.md
# Non-Volatile Word Store Data Port

This block is the data-side slave of an on-chip non-volatile word store. A host issues single-word program or read commands over a memory-mapped port with a wait signal. Before a command touches the storage array, the block checks it: the burst length must be one word, the address must be inside the populated range, and the sector holding the word must not be write-protected. A command that fails the check does not touch the array. It clears the matching success flag in the status outputs, and a failed read returns erased data (all ones).

The storage is modelled as a small word array that powers up erased. Programming can only clear bits, so a second program of a word without an erase in between leaves the bitwise AND of the old and new data. Program and read latencies are parameters given in clock cycles. The wait signal stays high for as long as a command is in flight. It is also held high whenever the control side reports that an erase is running.

Top module: `flash_data_port`

## Requirements
- R1: After reset the port shows busy code 2'b00, wait low when no erase is running, read-valid low, and both success flags at 0. Reset leaves array contents untouched.
- R2: A legal program command is accepted on the clock edge where it is presented while the port is idle. After that edge, busy reads 2'b10 and wait stays high for exactly PROG_LAT cycles. Then busy returns to 2'b00 and the write-success flag is 1.
- R3: A legal program changes the stored word to the AND of its previous value and the new data.
- R4: A program command fails if its burst count is not 1, its address is at or beyond DEPTH, or its sector is protected. A failed program clears write-success on the accepting edge, leaves busy at 2'b00, and changes no stored word.
- R5: Every read command is accepted on the edge where it is presented while idle. After that edge, busy reads 2'b11 and wait stays high for READ_LAT cycles. In the following cycle read-valid is high for exactly one cycle.
- R6: A legal read returns the stored word with read-success set to 1.
- R7: A read fails if its burst count is not 1, its address is at or beyond DEPTH, or its sector is protected. A failed read returns 32'hFFFF_FFFF with read-success 0.
- R8: Words never programmed since power-up read as 32'hFFFF_FFFF.
- R9: While erase_busy_i is high, wait is high and no command is accepted.
- R10: The sector of an address is addr / SECT_WORDS. Bit s of wp_i protects sector s, and a 1 means protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address of the command |
| read_i | input | 1 | Read command request |
| write_i | input | 1 | Program command request |
| wdata_i | input | 32 | Program data |
| burst_i | input | BURST_W | Burst count of the command |
| wp_i | input | NUM_SECT | Per-sector protection bits from the control side |
| erase_busy_i | input | 1 | Control side erase in progress |
| waitreq_o | output | 1 | Command not accepted / port busy |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle per read |
| busy_o | output | 2 | 00 idle, 10 programming, 11 reading |
| rd_ok_o | output | 1 | Result of the last read |
| wr_ok_o | output | 1 | Result of the last program |

## Verification
The assertions assume that the host holds a command only until the cycle it is accepted, and never raises read and program together. They also assume that erase_busy_i rises only while the port is idle and no command is pending. The bench keeps to these rules: it drives one command at a time on the falling edge, drops it after the accepting edge, and asserts the erase indication only between commands. It sweeps every address in the 5-bit space, including the unpopulated top range, over several data patterns and all protection masks, and checks read data against a bench-side model that ANDs each legal program into an all-ones array.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PROG = 2'b10,
    ST_READ = 2'b11
  } fdp_state_e;
endpackage

// File: rtl/fdp_req_check.sv
module fdp_req_check #(
  parameter int ADDR_W     = 5,
  parameter int BURST_W    = 3,
  parameter int DEPTH      = 24,
  parameter int SECT_WORDS = 8,
  localparam int NUM_SECT  = (DEPTH + SECT_WORDS - 1) / SECT_WORDS
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BURST_W-1:0]  burst_i,
  input  logic [NUM_SECT-1:0] wp_i,
  output logic                legal_o
);
  logic [31:0]         addr_ext;
  logic [NUM_SECT-1:0] sect_hit;
  logic                in_range;

  assign addr_ext = 32'(addr_i);
  assign in_range = addr_ext < 32'(DEPTH);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign sect_hit[s] = (addr_ext >= 32'(s * SECT_WORDS)) &&
                         (addr_ext < 32'((s + 1) * SECT_WORDS));
  end

  assign legal_o = (burst_i == BURST_W'(1)) && in_range && !(|(sect_hit & wp_i));
endmodule

// File: rtl/fdp_array.sv
module fdp_array #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 24
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] mem_q [DEPTH];

  // power-up content is the erased state
  initial begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] = '1;
  end

  // programming only clears bits
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= mem_q[addr_i] & wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/fdp_seq.sv
module fdp_seq
  import fdp_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int PROG_LAT = 4,
  parameter int READ_LAT = 2,
  localparam int MAX_LAT = (PROG_LAT > READ_LAT) ? PROG_LAT : READ_LAT,
  localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_i,
  input  logic              write_i,
  input  logic              erase_busy_i,
  input  logic              legal_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              waitreq_o,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic [1:0]        busy_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);
  fdp_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic              rd_legal_q;
  logic              idle, last;

  assign idle = (state_q == ST_IDLE);
  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      rd_legal_q <= 1'b0;
      rdata_o    <= '1;
      rvalid_o   <= 1'b0;
      rd_ok_o    <= 1'b0;
      wr_ok_o    <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!erase_busy_i && write_i) begin
            if (legal_i) begin
              state_q <= ST_PROG;
              cnt_q   <= CNT_W'(PROG_LAT - 1);
              addr_q  <= addr_i;
              data_q  <= wdata_i;
            end else begin
              wr_ok_o <= 1'b0;
            end
          end else if (!erase_busy_i && read_i) begin
            state_q    <= ST_READ;
            cnt_q      <= CNT_W'(READ_LAT - 1);
            addr_q     <= addr_i;
            rd_legal_q <= legal_i;
          end
        end
        ST_PROG: begin
          if (last) begin
            state_q <= ST_IDLE;
            wr_ok_o <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_READ: begin
          if (last) begin
            state_q  <= ST_IDLE;
            rvalid_o <= 1'b1;
            rdata_o  <= rd_legal_q ? mem_rdata_i : '1;
            rd_ok_o  <= rd_legal_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we_o    = (state_q == ST_PROG) && last;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign waitreq_o   = !idle || erase_busy_i;
  assign busy_o      = state_q;
endmodule

// File: rtl/flash_data_port.sv
module flash_data_port #(
  parameter int ADDR_W     = 5,
  parameter int BURST_W    = 3,
  parameter int DEPTH      = 24,
  parameter int SECT_WORDS = 8,
  parameter int PROG_LAT   = 4,
  parameter int READ_LAT   = 2,
  localparam int NUM_SECT  = (DEPTH + SECT_WORDS - 1) / SECT_WORDS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                read_i,
  input  logic                write_i,
  input  logic [31:0]         wdata_i,
  input  logic [BURST_W-1:0]  burst_i,
  input  logic [NUM_SECT-1:0] wp_i,
  input  logic                erase_busy_i,
  output logic                waitreq_o,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  output logic [1:0]          busy_o,
  output logic                rd_ok_o,
  output logic                wr_ok_o
);
  logic              legal;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;

  fdp_req_check #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS)
  ) i_check (
    .addr_i(addr_i), .burst_i(burst_i), .wp_i(wp_i), .legal_o(legal)
  );

  fdp_seq #(
    .ADDR_W(ADDR_W), .PROG_LAT(PROG_LAT), .READ_LAT(READ_LAT)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .read_i(read_i), .write_i(write_i),
    .erase_busy_i(erase_busy_i), .legal_i(legal), .addr_i(addr_i),
    .wdata_i(wdata_i), .mem_rdata_i(mem_rdata), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .waitreq_o(waitreq_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .busy_o(busy_o),
    .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o)
  );

  fdp_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_array (
    .clk_i(clk_i), .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        erase_busy_i,
  input logic        waitreq_o,
  input logic [31:0] rdata_o,
  input logic        rvalid_o,
  input logic [1:0]  busy_o,
  input logic        rd_ok_o
);
  AST_BUSY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != 2'b00) |-> waitreq_o); // R2
  AST_ERASE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_busy_i |-> waitreq_o); // R9
  AST_BUSY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o != 2'b01); // R5
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(busy_o) == 2'b11); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R5
  AST_BAD_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rd_ok_o) |-> (rdata_o == 32'hFFFF_FFFF)); // R7
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o == 2'b00); // R5
endmodule

bind flash_data_port fdp_checker i_fdp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .erase_busy_i(erase_busy_i),
  .waitreq_o(waitreq_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .busy_o(busy_o), .rd_ok_o(rd_ok_o)
);

// File: tb/test_flash_data_port.sv
module test_flash_data_port;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5, BURST_W = 3, DEPTH = 24, SECT_WORDS = 8;
  localparam int PROG_LAT = 4, READ_LAT = 2, NUM_SECT = 3;

  logic                clk = 1'b0, rst_ni = 1'b0;
  logic [ADDR_W-1:0]   addr = '0;
  logic                rd = 1'b0, wr = 1'b0, erase_busy = 1'b0;
  logic [31:0]         wdata = '0;
  logic [BURST_W-1:0]  burst = 3'd1;
  logic [NUM_SECT-1:0] wp = '0;
  logic                waitreq, rvalid, rd_ok, wr_ok;
  logic [31:0]         rdata;
  logic [1:0]          busy;

  int total = 0, bad = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_data_port i_flash_data_port (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .read_i(rd), .write_i(wr),
    .wdata_i(wdata), .burst_i(burst), .wp_i(wp), .erase_busy_i(erase_busy),
    .waitreq_o(waitreq), .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int a, input int b);
    return (b == 1) && (a < DEPTH) && !wp[a / SECT_WORDS]; // R10
  endfunction

  task automatic do_write(input int a, input logic [31:0] d, input int b);
    bit ok = legal(a, b);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; burst = BURST_W'(b); wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    if (ok) begin
      for (int i = 0; i < PROG_LAT; i++) begin
        chk(busy == 2'b10 && waitreq, "R2", {30'd0, busy}, 32'd2);
        @(negedge clk);
      end
      chk(busy == 2'b00 && !waitreq, "R2", {30'd0, busy}, 32'd0);
      chk(wr_ok == 1'b1, "R2", {31'd0, wr_ok}, 32'd1);
      model[a] = model[a] & d; // R3
    end else begin
      chk(busy == 2'b00 && !waitreq, "R4", {30'd0, busy}, 32'd0);
      chk(wr_ok == 1'b0, "R4", {31'd0, wr_ok}, 32'd0);
    end
  endtask

  task automatic do_read(input int a, input int b, input string req);
    bit ok = legal(a, b);
    logic [31:0] exp = ok ? model[a] : 32'hFFFF_FFFF;
    @(negedge clk);
    addr = ADDR_W'(a); burst = BURST_W'(b); rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    for (int i = 0; i < READ_LAT; i++) begin
      chk(busy == 2'b11 && waitreq && !rvalid, "R5", {30'd0, busy}, 32'd3);
      @(negedge clk);
    end
    chk(rvalid == 1'b1, "R5", {31'd0, rvalid}, 32'd1);
    chk(rdata == exp, req, rdata, exp);
    chk(rd_ok == ok, ok ? "R6" : "R7", {31'd0, rd_ok}, {31'd0, ok});
    @(negedge clk);
    chk(rvalid == 1'b0, "R5", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 2'b00 && !waitreq && !rvalid, "R1", {30'd0, busy}, 32'd0);
    chk(!rd_ok && !wr_ok, "R1", {30'd0, rd_ok, wr_ok}, 32'd0);
    rst_ni = 1'b1;
    // R8 fresh array reads erased, including beyond DEPTH (R7)
    for (int a = 0; a < 32; a++) do_read(a, 1, a < DEPTH ? "R8" : "R7");
    // R3 program patterns, then re-program to get AND
    for (int a = 0; a < DEPTH; a++) do_write(a, 32'hA5C3_0FF0 ^ (a * 32'h0101_1011), 1);
    for (int a = 0; a < DEPTH; a++) do_read(a, 1, "R3");
    for (int a = 0; a < DEPTH; a += 3) do_write(a, ~(32'h1 << a), 1);
    for (int a = 0; a < DEPTH; a++) do_read(a, 1, "R3");
    // R4 bad burst and out-of-range programs
    for (int b = 0; b < 8; b++) if (b != 1) begin
      do_write(5, 32'h0, 1);
      do_write(6, 32'h0, b);
      do_read(6, 1, "R4");
      do_read(6, b, "R7");
    end
    for (int a = DEPTH; a < 32; a++) do_write(a, 32'h0, 1);
    // R10 protection sweep over all masks
    for (int m = 0; m < 8; m++) begin
      wp = NUM_SECT'(m);
      for (int s = 0; s < NUM_SECT; s++) begin
        do_write(s * SECT_WORDS + 7 - m, 32'hFFFF_0000 >> m, 1);
        do_read(s * SECT_WORDS + 7 - m, 1, "R10");
        do_read(s * SECT_WORDS + 1, 1, "R10");
      end
    end
    wp = '0;
    // R9 erase stall
    @(negedge clk);
    erase_busy = 1'b1; addr = 5'd9; wdata = 32'h0; burst = 3'd1; wr = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(waitreq && busy == 2'b00, "R9", {31'd0, waitreq}, 32'd1);
    end
    wr = 1'b0; rd = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(waitreq && busy == 2'b00 && !rvalid, "R9", {30'd0, busy}, 32'd0);
    end
    rd = 1'b0; erase_busy = 1'b0;
    @(negedge clk);
    chk(!waitreq, "R9", {31'd0, waitreq}, 32'd0);
    do_read(9, 1, "R9");
    // R1 reset keeps array contents
    do_write(2, 32'h1234_5678, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(busy == 2'b00 && !wr_ok && !rd_ok && !rvalid, "R1", {30'd0, busy}, 32'd0);
    rst_ni = 1'b1;
    do_read(2, 1, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule